// File: doc/BRIEF.md
# Disk Request Scheduling Engine

The engine keeps a queue of pending disk requests. Each request is named only by its target cylinder. The engine also tracks the cylinder the head currently sits over. Whenever the consumer accepts a request through the service handshake, the engine removes the request chosen by the selected head-movement policy. It then moves the head to that cylinder and adds the distance travelled to a running movement total.

Five policies share the one queue:

- arrival order;
- nearest cylinder first;
- an end-to-end sweep that reverses at the disk edges;
- a one-way sweep that returns to cylinder 0 at the top edge;
- a one-way sweep that jumps back as soon as no request lies ahead.

The selection is presented combinationally from registered state, so the chosen cylinder is visible before the handshake. A start-position load places the head anywhere before or between services.

Top module: `disk_sched_engine`

## Requirements
- R1: Cylinders span 0..199. A push whose cylinder exceeds 199 is rejected and does not set the overflow flag. A load above 199 places the head at 199.
- R2: Policy code 0 (also 5, 6, 7) picks the oldest queued request. On a service (serve_ready high while out_valid is high and load_valid is low), that request leaves the queue and the head moves to its cylinder.
- R3: Policy code 1 picks the request closest to the head. Equal distances go to the lower cylinder, and equal cylinders go to the older entry.
- R4: Policy code 2 sweeps. In the up direction it picks the lowest cylinder at or above the head. If there is none, it travels to 199 and back down to the highest request, and the direction becomes down. In the down direction it picks the highest cylinder at or below the head. If there is none, it travels to 0 and back up to the lowest request, and the direction becomes up. The movement counted includes the trip to the edge.
- R5: Policy code 3 picks the lowest cylinder at or above the head. If there is none, it picks the lowest queued cylinder, and the movement counted is (199 - head) + 199 + target.
- R6: Policy code 4 picks the lowest cylinder at or above the head. If there is none, it picks the lowest queued cylinder, and the movement counted is head - target.
- R7: Each service adds its movement to total_move. From head 53 with requests 98, 183, 37, 122, 14, 124, 65, 67, draining the queue totals 640 under code 0 and 236 under code 1. Without a service, the total is unchanged.
- R8: The queue holds 16 entries. An in-range push while 16 are held is dropped, even if a service happens in the same cycle, and it sets overflow. Overflow stays high until reset.
- R9: With the queue empty, out_valid is low, a service request is ignored, and head and direction hold.
- R10: The policy input is read at each selection. The sweep direction persists across policy changes. Reset gives an empty queue, head 0, direction up, total 0 and overflow low.
- R11: load_valid sets the head and blocks any service in the same cycle. A push in that cycle is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Enqueue a request this cycle |
| push_cyl | input | 8 | Cylinder of the pushed request |
| policy | input | 3 | Scheduling policy code |
| load_valid | input | 1 | Load the head position |
| load_cyl | input | 8 | Head position to load |
| serve_ready | input | 1 | Consumer accepts the presented request |
| out_valid | output | 1 | A request is presented |
| out_cyl | output | 8 | Cylinder of the presented request |
| total_move | output | 20 | Accumulated head movement, wrapping |
| overflow | output | 1 | Sticky: a push was dropped on a full queue |

## Verification
Head position and sweep direction are internal. A corrupted head or direction shows at out_cyl on the next presentation under any positional policy. It also shows in total_move right after the next service. A queue that loses, duplicates or reorders entries shows as a wrong out_cyl under the arrival-order policy, or as a wrong out_valid when the count runs out early or late. The bench compares every port every cycle against a reference model. A wrong internal state therefore surfaces within one cycle of the first service that depends on it.

// File: rtl/disk_sched_pkg.sv
package disk_sched_pkg;
    typedef enum logic [2:0] {
        POL_ORDER  = 3'd0,
        POL_NEAR   = 3'd1,
        POL_SWEEP  = 3'd2,
        POL_RETURN = 3'd3,
        POL_JUMP   = 3'd4
    } policy_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/disk_sched_queue.sv
module disk_sched_queue #(
    parameter int DEPTH = 16,
    parameter int CW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_en,
    input  logic [CW-1:0]             push_cyl,
    input  logic                      pop_en,
    input  logic [AW-1:0]             pop_idx,
    output logic [DEPTH-1:0][CW-1:0]  entries,
    output logic [NW-1:0]             count,
    output logic                      full
);
    typedef struct packed {
        logic [DEPTH-1:0][CW-1:0] ent;
        logic [NW-1:0]            cnt;
    } qstate_t;

    qstate_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (pop_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (AW'(i) >= pop_idx) st_d.ent[i] = st_q.ent[i+1];
            end
            st_d.cnt = st_q.cnt - NW'(1);
        end
        if (push_en) begin
            st_d.ent[st_d.cnt[AW-1:0]] = push_cyl;
            st_d.cnt = st_d.cnt + NW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign entries = st_q.ent;
    assign count   = st_q.cnt;
    assign full    = (st_q.cnt == NW'(DEPTH));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= NW'(DEPTH));
    p_full_blocks_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_en);
    p_pop_shrinks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en) |=> count == $past(count) - NW'(1));
endmodule

// File: rtl/disk_sched_picker.sv
module disk_sched_picker
    import disk_sched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 8,
    parameter int MAXC  = 199,
    localparam int AW   = $clog2(DEPTH),
    localparam int NW   = $clog2(DEPTH + 1),
    localparam int MW   = CW + 2
) (
    input  logic [DEPTH-1:0][CW-1:0] entries,
    input  logic [NW-1:0]            count,
    input  logic [CW-1:0]            head,
    input  logic                     dir_up,
    input  logic [2:0]               policy,
    output logic [AW-1:0]            sel_idx,
    output logic [CW-1:0]            sel_cyl,
    output logic [MW-1:0]            move,
    output logic                     dir_next
);
    localparam logic [MW-1:0] EDGE = MW'(MAXC);

    logic [CW-1:0] c, d, near_d, near_c, ge_c, le_c, mn_c, mx_c;
    logic [AW-1:0] near_i, ge_i, le_i, mn_i, mx_i;
    logic          f_ge, f_le, f_any;
    logic [MW-1:0] hw;

    always_comb begin
        near_d = '1; near_c = '1; near_i = '0;
        ge_c = '0; ge_i = '0; f_ge = 1'b0;
        le_c = '0; le_i = '0; f_le = 1'b0;
        mn_c = '0; mn_i = '0; mx_c = '0; mx_i = '0; f_any = 1'b0;
        c = '0; d = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (NW'(i) < count) begin
                c = entries[i];
                d = (c >= head) ? c - head : head - c;
                if (d < near_d || (d == near_d && c < near_c)) begin
                    near_d = d; near_c = c; near_i = AW'(i);
                end
                if (c >= head && (!f_ge || c < ge_c)) begin
                    f_ge = 1'b1; ge_c = c; ge_i = AW'(i);
                end
                if (c <= head && (!f_le || c > le_c)) begin
                    f_le = 1'b1; le_c = c; le_i = AW'(i);
                end
                if (!f_any || c < mn_c) begin mn_c = c; mn_i = AW'(i); end
                if (!f_any || c > mx_c) begin mx_c = c; mx_i = AW'(i); end
                f_any = 1'b1;
            end
        end
    end

    always_comb begin
        hw       = MW'(head);
        dir_next = dir_up;
        sel_idx  = '0;
        sel_cyl  = entries[0];
        move     = '0;
        case (policy)
            POL_NEAR: begin
                sel_idx = near_i; sel_cyl = near_c; move = MW'(near_d);
            end
            POL_SWEEP: begin
                if (dir_up) begin
                    if (f_ge) begin
                        sel_idx = ge_i; sel_cyl = ge_c; move = MW'(ge_c) - hw;
                    end else begin
                        sel_idx = mx_i; sel_cyl = mx_c;
                        move = (EDGE - hw) + (EDGE - MW'(mx_c));
                        dir_next = DIR_DOWN;
                    end
                end else begin
                    if (f_le) begin
                        sel_idx = le_i; sel_cyl = le_c; move = hw - MW'(le_c);
                    end else begin
                        sel_idx = mn_i; sel_cyl = mn_c;
                        move = hw + MW'(mn_c);
                        dir_next = DIR_UP;
                    end
                end
            end
            POL_RETURN, POL_JUMP: begin
                if (f_ge) begin
                    sel_idx = ge_i; sel_cyl = ge_c; move = MW'(ge_c) - hw;
                end else begin
                    sel_idx = mn_i; sel_cyl = mn_c;
                    if (policy == POL_RETURN)
                        move = (EDGE - hw) + EDGE + MW'(mn_c);
                    else
                        move = hw - MW'(mn_c);
                end
            end
            default: begin
                sel_idx = '0;
                sel_cyl = entries[0];
                move = (entries[0] >= head) ? MW'(entries[0] - head)
                                            : MW'(head - entries[0]);
            end
        endcase
    end
endmodule

// File: rtl/disk_sched_engine.sv
module disk_sched_engine
    import disk_sched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 8,
    parameter int MAXC  = 199,
    parameter int TW    = 20,
    localparam int AW   = $clog2(DEPTH),
    localparam int NW   = $clog2(DEPTH + 1),
    localparam int MW   = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [CW-1:0] push_cyl,
    input  logic [2:0]    policy,
    input  logic          load_valid,
    input  logic [CW-1:0] load_cyl,
    input  logic          serve_ready,
    output logic          out_valid,
    output logic [CW-1:0] out_cyl,
    output logic [TW-1:0] total_move,
    output logic          overflow
);
    localparam logic [CW-1:0] LAST = CW'(MAXC);

    typedef struct packed {
        logic [CW-1:0] head;
        logic          dir_up;
        logic [TW-1:0] total;
        logic          ovf;
    } hstate_t;

    hstate_t st_q, st_d;

    logic [DEPTH-1:0][CW-1:0] entries;
    logic [NW-1:0]            count;
    logic                     full;
    logic [AW-1:0]            sel_idx;
    logic [CW-1:0]            sel_cyl;
    logic [MW-1:0]            move;
    logic                     dir_next;
    logic                     in_range, push_en, serve;

    assign in_range = (push_cyl <= LAST);
    assign push_en  = push_valid && in_range && !full;
    assign serve    = serve_ready && (count != '0) && !load_valid;

    disk_sched_queue #(.DEPTH(DEPTH), .CW(CW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_cyl(push_cyl),
        .pop_en(serve), .pop_idx(sel_idx),
        .entries(entries), .count(count), .full(full)
    );

    disk_sched_picker #(.DEPTH(DEPTH), .CW(CW), .MAXC(MAXC)) u_picker (
        .entries(entries), .count(count), .head(st_q.head),
        .dir_up(st_q.dir_up), .policy(policy),
        .sel_idx(sel_idx), .sel_cyl(sel_cyl), .move(move),
        .dir_next(dir_next)
    );

    always_comb begin
        st_d = st_q;
        if (load_valid) begin
            st_d.head = (load_cyl > LAST) ? LAST : load_cyl;
        end else if (serve) begin
            st_d.head   = sel_cyl;
            st_d.dir_up = dir_next;
            st_d.total  = st_q.total + TW'(move);
        end
        if (push_valid && in_range && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.dir_up <= DIR_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = (count != '0);
    assign out_cyl    = sel_cyl;
    assign total_move = st_q.total;
    assign overflow   = st_q.ovf;

    p_head_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.head <= LAST);
    p_queue_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cyl <= LAST);
    p_head_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        serve |=> st_q.head == $past(out_cyl));
    p_sel_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> NW'(sel_idx) < count);
    p_total_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !serve |=> $stable(total_move));
    p_no_overflow_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    p_hold_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !load_valid) |=> ($stable(st_q.head) && $stable(st_q.dir_up)));
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_cyl <= LAST) |=> st_q.head == $past(load_cyl));
endmodule

// File: tb/disk_sched_engine_test.sv
module disk_sched_engine_test;
    localparam int LASTC = 199;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_cyl = '0;
    logic [2:0] policy = '0;
    logic       load_valid = 1'b0;
    logic [7:0] load_cyl = '0;
    logic       serve_ready = 1'b0;
    logic        out_valid;
    logic [7:0]  out_cyl;
    logic [19:0] total_move;
    logic        overflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int mq[16];
    int mcnt, mhead, mdir, mtot;
    bit movf;

    always #10 clk = ~clk;

    disk_sched_engine uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_cyl(push_cyl),
        .policy(policy), .load_valid(load_valid), .load_cyl(load_cyl),
        .serve_ready(serve_ready), .out_valid(out_valid), .out_cyl(out_cyl),
        .total_move(total_move), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic string tag_of(input int pol);
        case (pol)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R2";
        endcase
    endfunction

    // reference choice: index, movement, direction afterwards
    function automatic void mpick(input int pol, output int idx, output int mv, output int nd);
        int best, ahead, behind, lo, hi;
        best = -1; ahead = -1; behind = -1; lo = -1; hi = -1;
        nd = mdir;
        for (int k = 0; k < mcnt; k++) begin
            if (best < 0 || absd(mq[k], mhead) < absd(mq[best], mhead) ||
                (absd(mq[k], mhead) == absd(mq[best], mhead) && mq[k] < mq[best]))
                best = k;
            if (mq[k] >= mhead && (ahead < 0 || mq[k] < mq[ahead])) ahead = k;
            if (mq[k] <= mhead && (behind < 0 || mq[k] > mq[behind])) behind = k;
            if (lo < 0 || mq[k] < mq[lo]) lo = k;
            if (hi < 0 || mq[k] > mq[hi]) hi = k;
        end
        if (pol == 1) begin
            idx = best; mv = absd(mq[best], mhead);
        end else if (pol == 2) begin
            if (mdir == 1) begin
                if (ahead >= 0) begin idx = ahead; mv = mq[ahead] - mhead; end
                else begin idx = hi; mv = (LASTC - mhead) + (LASTC - mq[hi]); nd = 0; end
            end else begin
                if (behind >= 0) begin idx = behind; mv = mhead - mq[behind]; end
                else begin idx = lo; mv = mhead + mq[lo]; nd = 1; end
            end
        end else if (pol == 3 || pol == 4) begin
            if (ahead >= 0) begin idx = ahead; mv = mq[ahead] - mhead; end
            else begin
                idx = lo;
                mv = (pol == 3) ? (LASTC - mhead) + LASTC + mq[lo] : mhead - mq[lo];
            end
        end else begin
            idx = 0; mv = absd(mq[0], mhead);
        end
    endfunction

    task automatic cyc(input bit pv, input int pc, input bit sv, input int pol,
                       input bit lv, input int lc);
        int idx, mv, nd;
        bit wasfull;
        @(negedge clk);
        push_valid = pv; push_cyl = 8'(pc); serve_ready = sv;
        policy = 3'(pol); load_valid = lv; load_cyl = 8'(lc);
        #2;
        check(out_valid == (mcnt > 0), "R9 out_valid", int'(out_valid), int'(mcnt > 0));
        idx = 0; mv = 0; nd = mdir;
        if (mcnt > 0) begin
            mpick(pol, idx, mv, nd);
            check(int'(out_cyl) == mq[idx], tag_of(pol), int'(out_cyl), mq[idx]);
        end
        check(int'(total_move) == (mtot & 20'hFFFFF), "R7 total", int'(total_move), mtot & 20'hFFFFF);
        check(overflow == movf, "R8 overflow", int'(overflow), int'(movf));
        wasfull = (mcnt == 16);
        if (lv) begin
            mhead = (lc > LASTC) ? LASTC : lc;
        end else if (sv && mcnt > 0) begin
            mhead = mq[idx]; mtot += mv; mdir = nd;
            for (int k = idx; k < 15; k++) mq[k] = mq[k+1];
            mcnt--;
        end
        if (pv && pc <= LASTC) begin
            if (wasfull) movf = 1;
            else begin mq[mcnt] = pc; mcnt++; end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; push_valid = 0; serve_ready = 0; load_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mcnt = 0; mhead = 0; mdir = 1; mtot = 0; movf = 0;
        #2;
        check(!out_valid && total_move == 0 && !overflow, "R10 reset",
              int'(out_valid) + int'(total_move) + int'(overflow), 0);
    endtask

    task automatic textbook(input int pol, input int expect_total, input string req);
        int reqs[8] = '{98, 183, 37, 122, 14, 124, 65, 67};
        do_reset();
        cyc(0, 0, 0, pol, 1, 53);
        foreach (reqs[k]) cyc(1, reqs[k], 0, pol, 0, 0);
        for (int k = 0; k < 8; k++) cyc(0, 0, 1, pol, 0, 0);
        cyc(0, 0, 0, pol, 0, 0);
        check(int'(total_move) == expect_total, req, int'(total_move), expect_total);
        check(!out_valid, "R9 drained", int'(out_valid), 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int pol;
        void'($urandom(32'd4242));
        do_reset();

        textbook(0, 640, "R7 order total");
        textbook(1, 236, "R7 nearest total");
        // sweep up from 53, turn at 199 and come back down to 14
        textbook(2, 331, "R4 sweep total");
        // one-way return: 53..183 then 146 + 199 + 14 + (37-14)
        textbook(3, 130 + 16 + 199 + 14 + 23, "R5 return total");
        // jump: 53..183 then back 169 to 14, then up 23 to 37
        textbook(4, 130 + 169 + 23, "R6 jump total");

        // R1: out-of-range push rejected, load saturates
        do_reset();
        cyc(1, 230, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 250);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        check(int'(total_move) == 199, "R1 saturated load", int'(total_move), 199);

        // R3 tie: head 100, requests 110 and 90 -> 90 first
        do_reset();
        cyc(0, 0, 0, 1, 1, 100);
        cyc(1, 110, 0, 1, 0, 0);
        cyc(1, 90, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check(out_cyl == 8'd90, "R3 tie lower", int'(out_cyl), 90);

        // R8: overflow, including full with same-cycle service
        do_reset();
        for (int k = 0; k < 16; k++) cyc(1, k * 10, 0, 0, 0, 0);
        cyc(1, 5, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        check(overflow == 1'b1, "R8 sticky", int'(overflow), 1);

        // R9/R11: empty service ignored, load blocks service
        do_reset();
        cyc(0, 0, 1, 2, 0, 0);
        cyc(1, 40, 1, 0, 1, 20);
        cyc(0, 0, 0, 0, 0, 0);
        check(out_valid && out_cyl == 8'd40, "R11 load blocks serve", int'(out_cyl), 40);

        // constrained random mix, R10 policy switching
        do_reset();
        pol = 0;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 19) == 0) pol = $urandom_range(0, 7);
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 210),
                $urandom_range(0, 2) == 0, pol,
                $urandom_range(0, 29) == 0, $urandom_range(0, 210));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule